// File: doc/BRIEF.md
# Dual-Core Reset Controller

This block distributes reset to a system with two processor cores and records why each reset happened. Fourteen reset sources reach it as one-cycle request pulses on a single vector. Each source resets a fixed set of domains: either core, either core's peripherals, or the debug logic. A source can also set a latch that keeps the second core in reset, choose the IO pad state, and drive the open-drain request on the external reset pin. When several requests arrive in the same cycle, their effects are combined.

A reset output asserts in the same cycle as the request that causes it. The output stays asserted while a two-stage synchronizer on the system clock drains, and is then released. Once the second core has been latched in reset, it stays there until the first core writes a release bit.

Each core has its own cause register. A request sets a bit in that register only if the request resets that core. The bits are sticky: only a power-on request or a write of one to the bit clears them. A small register port gives read and write access to the two cause registers and the release control. The block's own `rst` input acts exactly like a power-on request.

Top module: `rstctl_dual`

## Requirements
- R1: A power-on request (`req_i` bit 0), or the `rst` input, resets both cores, both peripheral sets and the debug logic. It also sets the second-core hold, sets `io_mode_o` to 2'b01 (high impedance) and asserts `pin_drv_o`.
- R2: An external-pin request (`req_i` bit 1) resets both cores and both peripheral sets, sets the hold and selects high impedance. It does not reset the debug logic and does not assert `pin_drv_o`.
- R3: The first core's watchdog (bit 4) and NMI watchdog (bit 5) requests act like R2 and also assert `pin_drv_o`. The first core's debugger reset (bit 6) and secure-code fault (bit 7) requests act like R2 and do not assert `pin_drv_o`.
- R4: The second core's watchdog (bit 9), NMI watchdog (bit 10), debugger reset (bit 11) and secure-code fault (bit 12) requests reset only the second core and its peripherals. They leave the hold, `io_mode_o` and `pin_drv_o` untouched.
- R5: A hibernate request (bit 2) resets both cores, both peripheral sets and the debug logic, and sets the hold. It sets `io_mode_o` to 2'b10 (isolated), which takes priority over high impedance. It does not assert `pin_drv_o`.
- R6: A self-test request (bit 8 for the first core, bit 13 for the second) resets only that core, not its peripherals. A test-reset request (bit 3) resets only the debug logic.
- R7: A reset output asserts in the same cycle as its request. It stays asserted for SYNC_STAGES further clock edges and is released at the edge after that. Requests arriving in the same cycle apply the union of their effects. `io_mode_o` is 2'b00 when neither pad state is active.
- R8: Once the hold is set, `core1_hold_o` and `core1_rst_o` stay asserted until a register write to address 2 with data bit 0 set. A write with bit 0 clear does not release the hold. If a hold-setting request arrives in the same cycle as the release write, the hold stays set.
- R9: Cause register bit n corresponds to `req_i` bit n. A request sets its bit in the first core's register (address 0) only if it resets the first core, and in the second core's register (address 1) only if it resets the second core. The new bit is visible from the clock edge after the request.
- R10: Cause bits stay set across later requests other than power-on. Writing a one to a bit clears that bit and leaves the other bits unchanged. A power-on request clears all bits and then sets only bit 0.
- R11: `reg_rdata_o` is registered: it shows the addressed register one edge after the address is applied. Address 2 reads the hold state in bit 0. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, behaves as a power-on request |
| req_i | input | 14 | One-cycle reset request pulses, one bit per source |
| reg_addr_i | input | 2 | Register address: 0 first-core cause, 1 second-core cause, 2 hold control |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 14 | Write data (ones clear cause bits; bit 0 releases the hold) |
| reg_rdata_o | output | 14 | Registered read data |
| core0_rst_o | output | 1 | First core reset |
| per0_rst_o | output | 1 | First core peripheral reset |
| core1_rst_o | output | 1 | Second core reset, including the hold |
| per1_rst_o | output | 1 | Second core peripheral reset |
| core1_hold_o | output | 1 | Second core hold latch state |
| dbg_rst_o | output | 1 | Debug logic reset |
| io_mode_o | output | 2 | Pad state: 00 normal, 01 high impedance, 10 isolated |
| pin_drv_o | output | 1 | Open-drain request to pull the external reset pin low |

## Verification
The hardest situation to reach from the ports is a pair of sources arriving in the same cycle, because each pair's combined domain set must be formed correctly. The bench sweeps every pair of the fourteen sources. Before each pair it releases the hold and waits for the synchronizers to drain, so that the outputs seen in the request cycle come only from the pair. Cause-register stickiness takes ordered sequences of requests, W1C writes and a final power-on request, with the results read back through the register port after each step.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  localparam int NSRC = 14;
  localparam int NDOM = 9;
  localparam int NSTR = 8;

  // request bit positions
  localparam int S_POR     = 0;
  localparam int S_PIN     = 1;
  localparam int S_HIB     = 2;
  localparam int S_TRST    = 3;
  localparam int S_C0_WD   = 4;
  localparam int S_C0_NMI  = 5;
  localparam int S_C0_DBG  = 6;
  localparam int S_C0_SCF  = 7;
  localparam int S_C0_BIST = 8;
  localparam int S_C1_WD   = 9;
  localparam int S_C1_NMI  = 10;
  localparam int S_C1_DBG  = 11;
  localparam int S_C1_SCF  = 12;
  localparam int S_C1_BIST = 13;

  // domain positions inside an effect vector
  localparam int D_CORE0 = 0;
  localparam int D_PER0  = 1;
  localparam int D_CORE1 = 2;
  localparam int D_PER1  = 3;
  localparam int D_DBG   = 4;
  localparam int D_HIZ   = 5;
  localparam int D_ISO   = 6;
  localparam int D_PIN   = 7;
  localparam int D_HOLD  = 8;

  localparam int A_CAUSE0 = 0;
  localparam int A_CAUSE1 = 1;
  localparam int A_CTRL   = 2;

  typedef enum logic [1:0] {
    IO_NORMAL = 2'b00,
    IO_HIZ    = 2'b01,
    IO_ISO    = 2'b10
  } io_mode_e;

  localparam logic [NDOM-1:0] M_C0   = NDOM'(1) << D_CORE0;
  localparam logic [NDOM-1:0] M_P0   = NDOM'(1) << D_PER0;
  localparam logic [NDOM-1:0] M_C1   = NDOM'(1) << D_CORE1;
  localparam logic [NDOM-1:0] M_P1   = NDOM'(1) << D_PER1;
  localparam logic [NDOM-1:0] M_DBG  = NDOM'(1) << D_DBG;
  localparam logic [NDOM-1:0] M_HIZ  = NDOM'(1) << D_HIZ;
  localparam logic [NDOM-1:0] M_ISO  = NDOM'(1) << D_ISO;
  localparam logic [NDOM-1:0] M_PIN  = NDOM'(1) << D_PIN;
  localparam logic [NDOM-1:0] M_HOLD = NDOM'(1) << D_HOLD;
  localparam logic [NDOM-1:0] M_ALL  = M_C0 | M_P0 | M_C1 | M_P1;
  localparam logic [NDOM-1:0] M_SYS  = M_ALL | M_HIZ | M_HOLD;

  function automatic logic [NDOM-1:0] src_effect(input int s);
    logic [NDOM-1:0] e;
    case (s)
      S_POR:                          e = M_SYS | M_DBG | M_PIN;
      S_PIN:                          e = M_SYS;
      S_HIB:                          e = M_ALL | M_DBG | M_ISO | M_HOLD;
      S_TRST:                         e = M_DBG;
      S_C0_WD, S_C0_NMI:              e = M_SYS | M_PIN;
      S_C0_DBG, S_C0_SCF:             e = M_SYS;
      S_C0_BIST:                      e = M_C0;
      S_C1_WD, S_C1_NMI,
      S_C1_DBG, S_C1_SCF:             e = M_C1 | M_P1;
      S_C1_BIST:                      e = M_C1;
      default:                        e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/rstctl_map.sv
module rstctl_map
  import rstctl_pkg::*;
(
  input  logic [NSRC-1:0]      req_i,
  output logic [NDOM-1:0]      hit_o,
  output logic [1:0][NSRC-1:0] log_o
);

  logic [NDOM-1:0] eff;

  always_comb begin
    hit_o = '0;
    log_o = '0;
    eff   = '0;
    for (int s = 0; s < NSRC; s++) begin
      eff = src_effect(s);
      if (req_i[s]) hit_o = hit_o | eff;
      log_o[0][s] = req_i[s] & eff[D_CORE0];
      log_o[1][s] = req_i[s] & eff[D_CORE1];
    end
  end

endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  output logic rst_o
);

  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst)        stg <= {STAGES{RST_VAL}};
    else if (hit_i) stg <= '1;
    else            stg <= stg << 1;
  end

  // assertion follows the request directly, release waits for the stages
  assign rst_o = hit_i | stg[STAGES-1];

endmodule

// File: rtl/rstctl_cause.sv
module rstctl_cause #(
  parameter int NBITS   = 14,
  parameter int POR_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_i,
  input  logic [NBITS-1:0] log_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] cause_o
);

  localparam logic [NBITS-1:0] POR_VAL = NBITS'(1) << POR_BIT;

  logic [NBITS-1:0] cause_q;

  always_ff @(posedge clk) begin
    if (rst || por_i) cause_q <= POR_VAL;
    else              cause_q <= (cause_q & ~clr_i) | log_i;
  end

  assign cause_o = cause_q;

endmodule

// File: rtl/rstctl_dual.sv
module rstctl_dual
  import rstctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic              core0_rst_o,
  output logic              per0_rst_o,
  output logic              core1_rst_o,
  output logic              per1_rst_o,
  output logic              core1_hold_o,
  output logic              dbg_rst_o,
  output logic [1:0]        io_mode_o,
  output logic              pin_drv_o
);

  localparam logic [NDOM-1:0] POR_EFF = src_effect(S_POR);
  localparam int              NCORE   = 2;

  logic [NDOM-1:0]        hit;
  logic [1:0][NSRC-1:0]   log_v;
  logic [NSTR-1:0]        dom_rst;
  logic [NCORE-1:0][NSRC-1:0] cause;
  logic                   hold_q;
  logic                   rel_wr;
  logic [NSRC-1:0]        rd_q;
  io_mode_e               io_sel;

  rstctl_map u_map (
    .req_i (req_i),
    .hit_o (hit),
    .log_o (log_v)
  );

  for (genvar d = 0; d < NSTR; d++) begin : g_dom
    rstctl_stretch #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (POR_EFF[d])
    ) u_str (
      .clk   (clk),
      .rst   (rst),
      .hit_i (hit[d]),
      .rst_o (dom_rst[d])
    );
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_cause
    logic [NSRC-1:0] clr;
    assign clr = (reg_we_i && reg_addr_i == ADDR_W'(c)) ? reg_wdata_i : '0;
    rstctl_cause #(
      .NBITS   (NSRC),
      .POR_BIT (S_POR)
    ) u_cause (
      .clk     (clk),
      .rst     (rst),
      .por_i   (req_i[S_POR]),
      .log_i   (log_v[c]),
      .clr_i   (clr),
      .cause_o (cause[c])
    );
  end

  // second-core hold latch, a new setting request beats a release
  assign rel_wr = reg_we_i && reg_addr_i == ADDR_W'(A_CTRL) && reg_wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst)              hold_q <= 1'b1;
    else if (hit[D_HOLD]) hold_q <= 1'b1;
    else if (rel_wr)      hold_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (reg_addr_i)
        ADDR_W'(A_CAUSE0): rd_q <= cause[0];
        ADDR_W'(A_CAUSE1): rd_q <= cause[1];
        ADDR_W'(A_CTRL):   rd_q <= {{(NSRC-1){1'b0}}, hold_q};
        default:           rd_q <= '0;
      endcase
    end
  end

  always_comb begin
    if (dom_rst[D_ISO])      io_sel = IO_ISO;
    else if (dom_rst[D_HIZ]) io_sel = IO_HIZ;
    else                     io_sel = IO_NORMAL;
  end

  assign core0_rst_o  = dom_rst[D_CORE0];
  assign per0_rst_o   = dom_rst[D_PER0];
  assign core1_rst_o  = dom_rst[D_CORE1] | hold_q;
  assign per1_rst_o   = dom_rst[D_PER1];
  assign core1_hold_o = hold_q;
  assign dbg_rst_o    = dom_rst[D_DBG];
  assign io_mode_o    = io_sel;
  assign pin_drv_o    = dom_rst[D_PIN];
  assign reg_rdata_o  = rd_q;

endmodule

// File: rtl/rstctl_dual_chk.sv
module rstctl_dual_chk
  import rstctl_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] req_i,
  input logic [1:0]      reg_addr_i,
  input logic            reg_we_i,
  input logic [NSRC-1:0] reg_wdata_i,
  input logic [NSRC-1:0] reg_rdata_o,
  input logic            core0_rst_o,
  input logic            per0_rst_o,
  input logic            core1_rst_o,
  input logic            per1_rst_o,
  input logic            core1_hold_o,
  input logic            dbg_rst_o,
  input logic [1:0]      io_mode_o,
  input logic            pin_drv_o
);

  a_r1_por_domains: assert property (@(posedge clk) disable iff (rst)
    req_i[S_POR] && !req_i[S_HIB] |-> core0_rst_o && per0_rst_o && core1_rst_o &&
      per1_rst_o && dbg_rst_o && pin_drv_o && io_mode_o == 2'b01);

  a_r1_por_hold: assert property (@(posedge clk) disable iff (rst)
    req_i[S_POR] |=> core1_hold_o);

  a_r5_hib_iso: assert property (@(posedge clk) disable iff (rst)
    req_i[S_HIB] |-> io_mode_o == 2'b10 && dbg_rst_o);

  a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
    core1_hold_o && !(reg_we_i && reg_addr_i == 2'd2 && reg_wdata_i[0]) |=> core1_hold_o);

  a_r8_hold_core: assert property (@(posedge clk) disable iff (rst)
    core1_hold_o |-> core1_rst_o);

  a_r7_min_width: assert property (@(posedge clk) disable iff (rst)
    $fell(core0_rst_o) |-> $past(core0_rst_o, 2));

  a_r11_idle_addr: assert property (@(posedge clk) disable iff (rst)
    reg_addr_i == 2'd3 |=> reg_rdata_o == '0);

endmodule

bind rstctl_dual rstctl_dual_chk u_chk (.*);

// File: tb/rstctl_dual_tb.sv
module rstctl_dual_tb;

  localparam int NS = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] req_i = '0;
  logic [1:0]    reg_addr_i = '0;
  logic          reg_we_i = 1'b0;
  logic [NS-1:0] reg_wdata_i = '0;
  logic [NS-1:0] reg_rdata_o;
  logic core0_rst_o, per0_rst_o, core1_rst_o, per1_rst_o, core1_hold_o, dbg_rst_o, pin_drv_o;
  logic [1:0] io_mode_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rstctl_dual u_dut (.*);

  // expected effect: {hold, pin, iso, hiz, dbg, p1, c1, p0, c0}
  function automatic logic [8:0] exp_eff(input int s);
    bit sys, c0, p0, c1, p1, dbg, hiz, iso, pin;
    sys = (s == 0) || (s == 1) || (s == 2) || (s >= 4 && s <= 7);
    c0  = sys || s == 8;
    p0  = sys;
    c1  = sys || (s >= 9 && s <= 13);
    p1  = sys || (s >= 9 && s <= 12);
    dbg = (s == 0) || (s == 2) || (s == 3);
    hiz = (s == 0) || (s == 1) || (s >= 4 && s <= 7);
    iso = (s == 2);
    pin = (s == 0) || (s == 4) || (s == 5);
    return {sys, pin, iso, hiz, dbg, p1, c1, p0, c0};
  endfunction

  // observable form: {pin, io[1:0], dbg, p1, c1, p0, c0}
  function automatic logic [7:0] obs_of(input logic [8:0] e, input bit hold);
    logic [1:0] io;
    io = e[6] ? 2'b10 : (e[5] ? 2'b01 : 2'b00);
    return {e[7], io, e[4], e[3], e[2] | hold, e[1], e[0]};
  endfunction

  function automatic logic [7:0] obs_dut();
    return {pin_drv_o, io_mode_o, dbg_rst_o, per1_rst_o, core1_rst_o, per0_rst_o, core0_rst_o};
  endfunction

  function automatic string tag_of(input int s);
    if (s == 0) return "R1";
    if (s == 1) return "R2";
    if (s == 2) return "R5";
    if (s >= 4 && s <= 7) return "R3";
    if (s >= 9 && s <= 12) return "R4";
    return "R6";
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [NS-1:0] d);
    @(negedge clk);
    reg_addr_i = a;
    @(negedge clk);
    #1 d = reg_rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    @(negedge clk);
    req_i = m;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic clean();
    wr(2'd0, '1);
    wr(2'd1, '1);
    wr(2'd2, 14'd1);
    idle(4);
  endtask

  logic [NS-1:0] rv;
  logic [8:0]    e;

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset outputs", obs_dut(), obs_of(exp_eff(0), 1'b1));
    chk("R1 reset hold", core1_hold_o, 1);
    rst = 1'b0;
    idle(4);
    #1;
    chk("R1 after reset", obs_dut(), 8'h04);
    rd(2'd0, rv); chk("R10 reset cause0", rv, 1);
    rd(2'd1, rv); chk("R10 reset cause1", rv, 1);
    rd(2'd2, rv); chk("R11 ctrl reads hold", rv, 1);

    // single-source sweep
    for (int s = 0; s < NS; s++) begin
      clean();
      #1 chk("R7 idle before request", obs_dut(), 8'h00);
      e = exp_eff(s);
      @(negedge clk);
      req_i = 14'(1) << s;
      #1 chk(tag_of(s), obs_dut(), obs_of(e, 1'b0));
      @(negedge clk);
      req_i = '0;
      #1 chk("R7 edge1", obs_dut(), obs_of(e, 1'b0));
      chk("R8 hold set", core1_hold_o, e[8]);
      @(negedge clk);
      #1 chk("R7 edge2", obs_dut(), obs_of(e, 1'b0));
      @(negedge clk);
      #1 chk("R7 release", obs_dut(), obs_of(9'd0, e[8]));
      rd(2'd0, rv); chk("R9 cause0", rv, e[0] ? (32'd1 << s) : 32'd0);
      rd(2'd1, rv); chk("R9 cause1", rv, e[2] ? (32'd1 << s) : 32'd0);
    end

    // pairwise union sweep
    for (int s = 0; s < NS; s++) begin
      for (int t = s + 1; t < NS; t++) begin
        wr(2'd2, 14'd1);
        @(negedge clk);
        req_i = (14'(1) << s) | (14'(1) << t);
        #1 chk("R7 union", obs_dut(), obs_of(exp_eff(s) | exp_eff(t), 1'b0));
        @(negedge clk);
        req_i = '0;
        idle(3);
      end
    end

    // stickiness, W1C and power-on clearing
    clean();
    pulse(14'(1) << 4);
    idle(3);
    pulse(14'(1) << 11);
    idle(3);
    rd(2'd0, rv); chk("R10 sticky cause0", rv, 14'h0010);
    rd(2'd1, rv); chk("R10 sticky cause1", rv, 14'h0810);
    wr(2'd1, 14'h0010);
    rd(2'd1, rv); chk("R10 w1c one bit", rv, 14'h0800);
    rd(2'd0, rv); chk("R10 w1c other reg", rv, 14'h0010);
    pulse(14'd1);
    idle(3);
    rd(2'd0, rv); chk("R10 por cause0", rv, 14'h0001);
    rd(2'd1, rv); chk("R10 por cause1", rv, 14'h0001);

    // hold latch
    idle(10);
    #1 chk("R8 still held", core1_rst_o, 1);
    wr(2'd2, 14'h0002);
    #1 chk("R8 bit0 clear no release", core1_hold_o, 1);
    pulse(14'(1) << 9);
    idle(3);
    #1 chk("R4 hold untouched", core1_hold_o, 1);
    @(negedge clk);
    reg_addr_i = 2'd2; reg_wdata_i = 14'd1; reg_we_i = 1'b1; req_i = 14'(1) << 1;
    @(negedge clk);
    reg_we_i = 1'b0; req_i = '0;
    #1 chk("R8 set beats release", core1_hold_o, 1);
    idle(3);
    wr(2'd2, 14'd1);
    #1 chk("R8 released", core1_rst_o, 0);
    rd(2'd2, rv); chk("R11 ctrl after release", rv, 0);
    rd(2'd3, rv); chk("R11 unused addr", rv, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule